// File: doc/BRIEF.md
# Conditional branch and loop resolver

This block settles the outcome of near conditional jumps and counted loop operations for a processor core whose status register holds carry, parity, zero, sign and overflow flags. On each accepted operation it takes a small operation code, the current flags, the count register, an address-size attribute, the address of the next sequential instruction and a signed relative displacement. One clock later it returns three results: whether the transfer is taken, the instruction pointer to continue from, and the count register value to write back with its write enable.

Flag conditions cover unsigned comparisons, signed comparisons and every single flag in both polarities. A count-zero jump tests either the low 16 bits or all 32 bits of the count and leaves the count alone. Three loop forms decrement the count and take the branch while it stays nonzero. The width of the decrement follows the address-size attribute. Two of the loop forms also require the zero flag to be set, or to be clear. The block has no instruction fetch, no opcode-byte decoder and no flag generation, and it produces only same-segment targets.

Top module: `branch_resolver`

## Requirements
- R1: While rst_n is low and on the first edge after it, out_valid, out_taken and out_count_we are 0 and out_next_ip and out_count are 0.
- R2: Results appear on the outputs one clock edge after an accepted operation (in_valid high). In a cycle with in_valid low, the next edge drives out_valid, out_taken and out_count_we to 0 and holds out_next_ip and out_count.
- R3: in_flags bit 0 is CF, bit 1 PF, bit 2 ZF, bit 3 SF, bit 4 OF. Unsigned ops are taken on these conditions: op 2 when CF=1, op 3 when CF=0, op 6 when (CF|ZF)=1, op 7 when (CF|ZF)=0.
- R4: Signed ops are taken on these conditions: op 12 when SF^OF=1, op 13 when SF^OF=0, op 14 when ((SF^OF)|ZF)=1, op 15 when ((SF^OF)|ZF)=0.
- R5: Single-flag ops are taken when the flag is 1 for op 0 (OF), op 4 (ZF), op 8 (SF) and op 10 (PF). For ops 1, 5, 9 and 11 the same flag must be 0. For all ops 0 to 15, bit 0 of the op inverts the test named by bits 4:1.
- R6: Op 16 (count-zero jump) is taken when the count is zero. When in_addr16=1 only the low 16 bits are tested, otherwise all 32 bits. It ignores every flag, returns the count unchanged and keeps out_count_we at 0.
- R7: Op 17 (loop) decrements the count and is taken when the decremented value is nonzero. When in_addr16=1 only the low 16 bits are decremented and tested and bits 31:16 pass through unchanged. Otherwise the full 32 bits are used.
- R8: The decrement wraps: a starting count of zero gives 0xFFFF in the low half (16-bit mode) or 0xFFFFFFFF (32-bit mode), and the loop is taken.
- R9: Op 18 is taken only when the decremented count is nonzero and ZF=1. Op 19 is taken only when it is nonzero and ZF=0. Both always write back the decremented count.
- R10: When the operation is taken, out_next_ip is in_ip plus the sign-extended in_disp, modulo 2^32. When it is not taken, out_next_ip equals in_ip.
- R11: out_count_we is 1 for ops 17 to 19, taken or not, and 0 for every other op. Ops 20 to 31 are never taken and return the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 5 | Operation code (see R3 to R11) |
| in_flags | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| in_count | input | 32 | Current count register |
| in_addr16 | input | 1 | 1 selects 16-bit count handling |
| in_ip | input | 32 | Address of the next sequential instruction |
| in_disp | input | 16 | Signed relative displacement |
| out_valid | output | 1 | Results valid |
| out_taken | output | 1 | Transfer taken |
| out_next_ip | output | 32 | Instruction pointer to continue from |
| out_count | output | 32 | Count value to write back |
| out_count_we | output | 1 | Count write enable |

## Verification
The bench targets the count edges. These are a loop starting at zero in both widths, a loop reaching exactly zero, and a 16-bit loop with a busy upper half. A design that decremented the full register in 16-bit mode would corrupt bits 31:16 or mis-take the branch, and one that tested before decrementing would skip the zero-start case. It also sets every flag during count-zero jumps and fixes ZF both ways on the qualified loops. A resolver that let flags leak in, or that skipped the write-back on a failed qualified loop, would show a wrong decision or a missing write enable. A negative displacement and an address wrap past 0xFFFFFFFF catch a zero-extended or saturated target adder.

// File: rtl/branch_res_pkg.sv
package branch_res_pkg;

    // Operation codes. Codes 0..15 are flag tests in complementary pairs:
    // bits 4:1 pick the test, bit 0 inverts it.
    localparam logic [4:0] OP_OVF      = 5'd0;
    localparam logic [4:0] OP_NOVF     = 5'd1;
    localparam logic [4:0] OP_BELOW    = 5'd2;
    localparam logic [4:0] OP_AEQ      = 5'd3;
    localparam logic [4:0] OP_EQ       = 5'd4;
    localparam logic [4:0] OP_NEQ      = 5'd5;
    localparam logic [4:0] OP_BEQ      = 5'd6;
    localparam logic [4:0] OP_ABOVE    = 5'd7;
    localparam logic [4:0] OP_NEG      = 5'd8;
    localparam logic [4:0] OP_NNEG     = 5'd9;
    localparam logic [4:0] OP_PEVEN    = 5'd10;
    localparam logic [4:0] OP_PODD     = 5'd11;
    localparam logic [4:0] OP_LESS     = 5'd12;
    localparam logic [4:0] OP_GEQ      = 5'd13;
    localparam logic [4:0] OP_LEQ      = 5'd14;
    localparam logic [4:0] OP_GREATER  = 5'd15;
    localparam logic [4:0] OP_CNTZ     = 5'd16;
    localparam logic [4:0] OP_LOOP     = 5'd17;
    localparam logic [4:0] OP_LOOP_Z   = 5'd18;
    localparam logic [4:0] OP_LOOP_NZ  = 5'd19;

    // Test selector carried in op bits 4:1 for the flag group
    typedef enum logic [2:0] {
        TST_OVF   = 3'd0,
        TST_CARRY = 3'd1,
        TST_ZERO  = 3'd2,
        TST_BE    = 3'd3,
        TST_SIGN  = 3'd4,
        TST_PAR   = 3'd5,
        TST_LT    = 3'd6,
        TST_LE    = 3'd7
    } br_test_e;

    // Status flags, bit 0 = CF ... bit 4 = OF
    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic pf_f;
        logic cf_f;
    } br_flags_t;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import branch_res_pkg::*;
(
    input  logic [3:0] op_lo,
    input  br_flags_t  flags,
    output logic       cond_true
);

    br_test_e test_sel;
    logic     raw_d;
    logic     lt_d;

    always_comb begin
        test_sel = br_test_e'(op_lo[3:1]);
        lt_d     = flags.sf_f ^ flags.of_f;
        unique case (test_sel)
            TST_OVF:   raw_d = flags.of_f;
            TST_CARRY: raw_d = flags.cf_f;
            TST_ZERO:  raw_d = flags.zf_f;
            TST_BE:    raw_d = flags.cf_f | flags.zf_f;
            TST_SIGN:  raw_d = flags.sf_f;
            TST_PAR:   raw_d = flags.pf_f;
            TST_LT:    raw_d = lt_d;
            TST_LE:    raw_d = lt_d | flags.zf_f;
            default:   raw_d = 1'b0;
        endcase
        cond_true = raw_d ^ op_lo[0];
    end

endmodule

// File: rtl/br_count_unit.sv
module br_count_unit #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic             addr16,
    output logic [CNT_W-1:0] count_dec,
    output logic             dec_nonzero,
    output logic             count_is_zero
);

    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0]  ONE_F = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [HALF_W-1:0] ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  full_dec_d;
    logic [HALF_W-1:0] half_dec_d;

    always_comb begin
        full_dec_d = count - ONE_F;
        half_dec_d = count[HALF_W-1:0] - ONE_H;
        if (addr16) begin
            count_dec     = {count[CNT_W-1:HALF_W], half_dec_d};
            dec_nonzero   = |half_dec_d;
            count_is_zero = ~|count[HALF_W-1:0];
        end else begin
            count_dec     = full_dec_d;
            dec_nonzero   = |full_dec_d;
            count_is_zero = ~|count;
        end
    end

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
    parameter int IP_W   = 32,
    parameter int DISP_W = 16
) (
    input  logic [IP_W-1:0]   ip,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   target
);

    logic [IP_W-1:0] disp_ext;

    generate
        if (DISP_W < IP_W) begin : g_sext
            assign disp_ext = {{(IP_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[IP_W-1:0];
        end
    endgenerate

    assign target = ip + disp_ext;

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import branch_res_pkg::*;
#(
    parameter int IP_W   = 32,
    parameter int CNT_W  = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_op,
    input  logic [4:0]        in_flags,
    input  logic [CNT_W-1:0]  in_count,
    input  logic              in_addr16,
    input  logic [IP_W-1:0]   in_ip,
    input  logic [DISP_W-1:0] in_disp,
    output logic              out_valid,
    output logic              out_taken,
    output logic [IP_W-1:0]   out_next_ip,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_count_we
);

    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic [IP_W-1:0]  next_ip;
        logic [CNT_W-1:0] count;
        logic             we;
    } res_t;

    res_t res_d, res_q;

    br_flags_t        flags_w;
    logic             cond_true;
    logic [CNT_W-1:0] count_dec;
    logic             dec_nonzero;
    logic             count_is_zero;
    logic [IP_W-1:0]  target;
    logic             is_loop;

    assign flags_w = br_flags_t'(in_flags);
    assign is_loop = (in_op == OP_LOOP) || (in_op == OP_LOOP_Z) || (in_op == OP_LOOP_NZ);

    br_cond_eval u_cond (
        .op_lo     (in_op[3:0]),
        .flags     (flags_w),
        .cond_true (cond_true)
    );

    br_count_unit #(.CNT_W(CNT_W)) u_count (
        .count         (in_count),
        .addr16        (in_addr16),
        .count_dec     (count_dec),
        .dec_nonzero   (dec_nonzero),
        .count_is_zero (count_is_zero)
    );

    br_target_gen #(.IP_W(IP_W), .DISP_W(DISP_W)) u_target (
        .ip     (in_ip),
        .disp   (in_disp),
        .target (target)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        res_d.taken = 1'b0;
        res_d.we    = 1'b0;
        if (in_valid) begin
            res_d.count = in_count;
            if (!in_op[4]) begin
                res_d.taken = cond_true;
            end else begin
                unique case (in_op)
                    OP_CNTZ: begin
                        res_d.taken = count_is_zero;
                    end
                    OP_LOOP: begin
                        res_d.taken = dec_nonzero;
                        res_d.count = count_dec;
                        res_d.we    = 1'b1;
                    end
                    OP_LOOP_Z: begin
                        res_d.taken = dec_nonzero & flags_w.zf_f;
                        res_d.count = count_dec;
                        res_d.we    = 1'b1;
                    end
                    OP_LOOP_NZ: begin
                        res_d.taken = dec_nonzero & ~flags_w.zf_f;
                        res_d.count = count_dec;
                        res_d.we    = 1'b1;
                    end
                    default: begin
                        res_d.taken = 1'b0;
                    end
                endcase
            end
            res_d.next_ip = res_d.taken ? target : in_ip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_taken    = res_q.taken;
    assign out_next_ip  = res_q.next_ip;
    assign out_count    = res_q.count;
    assign out_count_we = res_q.we;

    // Assertions
    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_count_we));  // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_next_ip) && $stable(out_count));  // R2
    AST_LOOP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_loop) |=> out_count_we);  // R11
    AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_loop) |=> (!out_count_we && out_count == $past(in_count)));  // R11
    AST_CNTZ_FLAGS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CNTZ) |=> (out_taken == ($past(in_addr16)
            ? ($past(in_count[HALF_W-1:0]) == '0) : ($past(in_count) == '0))));  // R6
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_loop && in_addr16) |=>
            out_count[CNT_W-1:HALF_W] == $past(in_count[CNT_W-1:HALF_W]));  // R7
    AST_FALLTHROUGH_IP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_taken || out_next_ip == $past(in_ip)));  // R10
    AST_HIGH_OPS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OP_LOOP_NZ) |=> !out_taken);  // R11
    AST_LOOPZ_NEEDS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LOOP_Z && !in_flags[2]) |=> !out_taken);  // R9
    AST_LOOPNZ_NEEDS_NZF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LOOP_NZ && in_flags[2]) |=> !out_taken);  // R9

endmodule

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [4:0]  in_flags = '0;
    logic [31:0] in_count = '0;
    logic        in_addr16 = 1'b0;
    logic [31:0] in_ip = '0;
    logic [15:0] in_disp = '0;
    logic        out_valid, out_taken, out_count_we;
    logic [31:0] out_next_ip, out_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    branch_resolver uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_flags(in_flags), .in_count(in_count), .in_addr16(in_addr16),
        .in_ip(in_ip), .in_disp(in_disp), .out_valid(out_valid),
        .out_taken(out_taken), .out_next_ip(out_next_ip),
        .out_count(out_count), .out_count_we(out_count_we)
    );

    // flags vector: {OF,SF,ZF,PF,CF}
    typedef struct packed {
        logic [4:0]  op;
        logic [4:0]  fl;
        logic        a16;
        logic [31:0] cnt;
        logic [31:0] ip;
        logic [15:0] disp;
        logic        etk;
        logic [31:0] ecnt;
        logic        ewe;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{5'd7,  5'b00000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd7,  5'b00001, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd7,  5'b00100, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd6,  5'b00100, 1'b0, 32'h5, 32'h1000, 16'hFFF0, 1'b1, 32'h5, 1'b0},
        '{5'd3,  5'b00001, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd2,  5'b00001, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd15, 5'b11000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd15, 5'b01000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd12, 5'b10000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd14, 5'b00100, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd13, 5'b01000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd10, 5'b00010, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd11, 5'b00010, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd0,  5'b10000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd1,  5'b00000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd9,  5'b01000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        '{5'd8,  5'b01000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd5,  5'b00000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b1, 32'h5, 1'b0},
        '{5'd4,  5'b00000, 1'b0, 32'h5, 32'h1000, 16'h0040, 1'b0, 32'h5, 1'b0},
        // count-zero jumps, all flags set
        '{5'd16, 5'b11111, 1'b1, 32'hABCD0000, 32'h1000, 16'h0040, 1'b1, 32'hABCD0000, 1'b0},
        '{5'd16, 5'b11111, 1'b0, 32'hABCD0000, 32'h1000, 16'h0040, 1'b0, 32'hABCD0000, 1'b0},
        '{5'd16, 5'b00000, 1'b0, 32'h0, 32'h1000, 16'hFF00, 1'b1, 32'h0, 1'b0},
        // plain loops
        '{5'd17, 5'b00000, 1'b0, 32'h1, 32'h1000, 16'hFFF0, 1'b0, 32'h0, 1'b1},
        '{5'd17, 5'b00000, 1'b0, 32'h2, 32'h1000, 16'hFFF0, 1'b1, 32'h1, 1'b1},
        '{5'd17, 5'b00000, 1'b1, 32'h12340001, 32'h1000, 16'hFFF0, 1'b0, 32'h12340000, 1'b1},
        '{5'd17, 5'b00000, 1'b1, 32'h12340000, 32'h1000, 16'hFFF0, 1'b1, 32'h1234FFFF, 1'b1}, // R8
        '{5'd17, 5'b00000, 1'b0, 32'h0, 32'h1000, 16'hFFF0, 1'b1, 32'hFFFFFFFF, 1'b1},        // R8
        // qualified loops
        '{5'd18, 5'b00100, 1'b0, 32'h3, 32'h1000, 16'hFFF0, 1'b1, 32'h2, 1'b1},
        '{5'd18, 5'b00000, 1'b0, 32'h3, 32'h1000, 16'hFFF0, 1'b0, 32'h2, 1'b1},
        '{5'd19, 5'b00000, 1'b0, 32'h3, 32'h1000, 16'hFFF0, 1'b1, 32'h2, 1'b1},
        '{5'd19, 5'b00100, 1'b0, 32'h3, 32'h1000, 16'hFFF0, 1'b0, 32'h2, 1'b1},
        // undefined code
        '{5'd25, 5'b11111, 1'b0, 32'h7, 32'h1000, 16'h0040, 1'b0, 32'h7, 1'b0},
        // address wrap
        '{5'd7,  5'b00000, 1'b0, 32'h5, 32'hFFFFFFF8, 16'h0010, 1'b1, 32'h5, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] op);
        if (op == 5'd2 || op == 5'd3 || op == 5'd6 || op == 5'd7) return "R3";
        if (op >= 5'd12 && op <= 5'd15) return "R4";
        if (op < 5'd16) return "R5";
        if (op == 5'd16) return "R6";
        if (op == 5'd17) return "R7";
        if (op == 5'd18 || op == 5'd19) return "R9";
        return "R11";
    endfunction

    function automatic logic [31:0] exp_ip(input logic tk, input logic [31:0] ip,
                                           input logic [15:0] d);
        return tk ? ip + {{16{d[15]}}, d} : ip;
    endfunction

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = v.op;
        in_flags  = v.fl;
        in_count  = v.cnt;
        in_addr16 = v.a16;
        in_ip     = v.ip;
        in_disp   = v.disp;
    endtask

    task automatic check_vec(input vec_t v);
        string r;
        r = req_of(v.op);
        chk("R2", "valid", {31'd0, out_valid}, 32'd1);
        chk(r, "taken", {31'd0, out_taken}, {31'd0, v.etk});
        chk("R10", "next_ip", out_next_ip, exp_ip(v.etk, v.ip, v.disp));
        chk(r, "count", out_count, v.ecnt);
        chk("R11", "count_we", {31'd0, out_count_we}, {31'd0, v.ewe});
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "taken", {31'd0, out_taken}, 32'd0);
        chk("R1", "count_we", {31'd0, out_count_we}, 32'd0);
        chk("R1", "next_ip", out_next_ip, 32'd0);
        chk("R1", "count", out_count, 32'd0);
        rst_n = 1'b1;

        // Table walk, one operation then a sample
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VEC[i]);
        end

        // R2: idle cycle quiets flags and holds data (last vector: ip 0x8, count 5)
        @(negedge clk);
        chk("R2", "idle valid", {31'd0, out_valid}, 32'd0);
        chk("R2", "idle taken", {31'd0, out_taken}, 32'd0);
        chk("R2", "idle next_ip", out_next_ip, 32'h8);
        chk("R2", "idle count", out_count, 32'h5);

        // R2: back-to-back operations, each result one edge later
        drive(VEC[26]);
        @(negedge clk);
        check_vec(VEC[26]);
        in_valid = 1'b1; in_op = VEC[4].op; in_flags = VEC[4].fl; in_count = VEC[4].cnt;
        in_addr16 = VEC[4].a16; in_ip = VEC[4].ip; in_disp = VEC[4].disp;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VEC[4]);

        // R8: 16-bit loop from zero with clear upper half
        drive('{5'd17, 5'b00000, 1'b1, 32'h0, 32'h2000, 16'h0004, 1'b1, 32'h0000FFFF, 1'b1});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "wrap taken", {31'd0, out_taken}, 32'd1);
        chk("R8", "wrap count", out_count, 32'h0000FFFF);
        chk("R10", "wrap ip", out_next_ip, 32'h2004);

        // R6: 16-bit count-zero with nonzero upper half and flags clear
        drive('{5'd16, 5'b00000, 1'b1, 32'hFFFF0000, 32'h3000, 16'h8000, 1'b1, 32'hFFFF0000, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6", "cntz16 taken", {31'd0, out_taken}, 32'd1);
        chk("R10", "cntz16 ip", out_next_ip, 32'hFFFFB000);
        chk("R6", "cntz16 count", out_count, 32'hFFFF0000);

        // R1: reset in mid-run clears the outputs
        drive(VEC[23]);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "re-reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "re-reset we", {31'd0, out_count_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule